// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the register bookkeeping a processor core needs at the moment it takes a trap. The core presents its current trap level, global level, condition codes, address space identifier, processor status word, hypervisor status word, window pointer, free-window count, and both program counters. It also presents a trap type and a destination class: privileged, hyperprivileged or the reduced-function recovery state. On a one-cycle request the unit pushes a frame onto a per-level save stack. The frame holds a packed status word, the two saved program counters, the saved hypervisor status and the trap type. In the same edge the unit registers the successor values of the trap level, global level, both status words and the window pointer. A `done` strobe marks the cycle in which those successor values are valid.

A separate power-on request loads the defined reset values instead. It has priority over a trap request in the same cycle. A combinational read port, addressed by level, returns any stored frame. The request is a plain strobe rather than a stream: the unit accepts one request per cycle, has no back-pressure, and never stalls the core.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, every successor output, `done` and `tick_lock` are zero, and every stack frame reads back as zero.
- R2: An accepted trap writes the frame at level `cur_tl+1`. The packed status word carries global level in bits 42:40, condition codes in 39:32, address space in 31:24, the status word in 20:8 and the window pointer in 4:0, and has zeros elsewhere.
- R3: When status bit 3 (address mask) is set, the saved PC and next-PC keep only their low 32 bits; otherwise they are saved whole.
- R4: An accepted trap yields `new_tl = cur_tl+1` and saves the incoming hypervisor status and the trap type in the frame. `done` is high for exactly the one cycle after the request edge.
- R5: The global level rises by one. It saturates at MAXPGL for destination 2'b00 (privileged) and at MAXGL for every other destination.
- R6: Privileged destination (2'b00): in the status word, bit 4 is set, bits 3 and 1 are cleared, bit 2 is set and bit 9 takes the value of bit 8. The hypervisor status is passed through unchanged.
- R7: Hyperprivileged destination (2'b01): in the status word, bit 4 is set and bits 3, 1 and 9 are cleared. In the hypervisor status, bit 2 is set, bits 5 and 10 are cleared and bit 0 is kept.
- R8: Recovery destination (2'b10 or 2'b11): the status word keeps only bit 2 and then has bit 4 set. In the hypervisor status, bits 5 and 2 are set and bits 10 and 0 are cleared.
- R9: The window pointer advances by 1 for type 0x024, by free-count+2 for types 0x080–0x0BF and goes back by 1 for types 0x0C0–0x0FF, in each case modulo NWINDOWS. Any other type leaves it unchanged.
- R10: Power-on request sets `new_tl`=MAXTL, `new_gl`=MAXGL and the status word to 0x014. In the hypervisor status it sets bits 5 and 2 and clears bits 10 and 0. It passes the window pointer through, raises `tick_lock` (held until reset) and pulses `done`.
- R11: A trap request with `cur_tl` at or above MAXTL is dropped: `done` stays low and every successor output keeps its value.
- R12: Power-on request in the same cycle as a trap request wins, and the trap is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request strobe |
| trap_dest | input | 2 | Destination: 00 privileged, 01 hyperprivileged, 1x recovery |
| trap_type | input | 9 | Trap type code |
| por_req | input | 1 | Power-on reset request |
| cur_tl | input | 3 | Current trap level |
| cur_gl | input | 2 | Current global level |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pstat | input | 13 | Current processor status word |
| cur_hstat | input | 11 | Current hypervisor status word |
| cur_cwp | input | 3 | Current window pointer |
| cur_cansave | input | 3 | Current free-window count |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next PC |
| rd_lvl | input | 3 | Stack read level (1..MAXTL) |
| new_tl | output | 3 | Successor trap level |
| new_gl | output | 2 | Successor global level |
| new_pstat | output | 13 | Successor processor status |
| new_hstat | output | 11 | Successor hypervisor status |
| new_cwp | output | 3 | Successor window pointer |
| tick_lock | output | 1 | Cycle-counter privileged-read lock bit |
| done | output | 1 | Successor values valid |
| rd_status | output | 43 | Frame packed status word |
| rd_pc | output | 64 | Frame saved PC |
| rd_npc | output | 64 | Frame saved next PC |
| rd_hstat | output | 11 | Frame saved hypervisor status |
| rd_type | output | 9 | Frame saved trap type |

## Verification
The case hardest to reach from the ports is the window pointer wrapping on a spill-range trap when a large free count pushes the sum past twice the window count's midpoint. Saturation of the global level at the privileged cap, as opposed to the overall cap, is also hard to reach. The stimulus covers both with directed vectors at pointer 7 and 0 and at global levels 2 and 3. Random vectors then draw trap types from each range class and mix the destinations. The dropped request at the top trap level is driven directly, and the held outputs are compared with a snapshot taken before it.

// File: rtl/trap_save_pkg.sv
`timescale 1ns/1ps
package trap_save_pkg;
  localparam int PS_W = 13;
  localparam int HS_W = 11;
  localparam int TY_W = 9;
  localparam int ST_W = 43;
  localparam int PC_W = 64;

  // status word bit positions
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;
  // hypervisor status bit positions
  localparam int HS_TLZ   = 0;
  localparam int HS_HPRIV = 2;
  localparam int HS_RED   = 5;
  localparam int HS_IBE   = 10;

  typedef enum logic [1:0] {
    DEST_PRIV = 2'b00,
    DEST_HYP  = 2'b01,
    DEST_RCV  = 2'b10,
    DEST_RCV2 = 2'b11
  } dest_e;

  typedef struct packed {
    logic [ST_W-1:0] status;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] npc;
    logic [HS_W-1:0] hstat;
    logic [TY_W-1:0] ttype;
  } frame_t;
endpackage

// File: rtl/trap_mode_rules.sv
`timescale 1ns/1ps
module trap_mode_rules
  import trap_save_pkg::*;
#(
  parameter int MAXGL  = 3,
  parameter int MAXPGL = 2,
  localparam int GL_W  = $clog2(MAXGL + 1)
) (
  input  logic [1:0]      dest,
  input  logic [PS_W-1:0] pstat,
  input  logic [HS_W-1:0] hstat,
  input  logic [GL_W-1:0] gl,
  output logic [PS_W-1:0] pstat_n,
  output logic [HS_W-1:0] hstat_n,
  output logic [GL_W-1:0] gl_n
);
  logic [GL_W-1:0] cap;

  always_comb begin
    cap  = (dest == DEST_PRIV) ? GL_W'(MAXPGL) : GL_W'(MAXGL);
    gl_n = (gl >= cap) ? cap : gl + 1'b1;

    pstat_n = pstat;
    hstat_n = hstat;
    if (dest[1]) begin
      pstat_n           = '0;
      pstat_n[PS_PRIV]  = pstat[PS_PRIV];
      pstat_n[PS_PEF]   = 1'b1;
      hstat_n[HS_RED]   = 1'b1;
      hstat_n[HS_HPRIV] = 1'b1;
      hstat_n[HS_IBE]   = 1'b0;
      hstat_n[HS_TLZ]   = 1'b0;
    end else begin
      pstat_n[PS_PEF] = 1'b1;
      pstat_n[PS_AM]  = 1'b0;
      pstat_n[PS_IE]  = 1'b0;
      if (dest[0]) begin
        pstat_n[PS_CLE]   = 1'b0;
        hstat_n[HS_RED]   = 1'b0;
        hstat_n[HS_HPRIV] = 1'b1;
        hstat_n[HS_IBE]   = 1'b0;
      end else begin
        pstat_n[PS_PRIV] = 1'b1;
        pstat_n[PS_CLE]  = pstat[PS_TLE];
      end
    end
  end
endmodule

// File: rtl/trap_window_step.sv
`timescale 1ns/1ps
module trap_window_step
  import trap_save_pkg::*;
#(
  parameter int NWINDOWS = 8,
  localparam int CWP_W   = $clog2(NWINDOWS),
  localparam int SW      = CWP_W + 2
) (
  input  logic [TY_W-1:0]  ttype,
  input  logic [CWP_W-1:0] cwp,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_n
);
  logic [SW-1:0] sum;

  always_comb begin
    if (ttype == TY_W'(9'h024))
      sum = SW'(cwp) + SW'(1);
    else if (ttype[8:6] == 3'b010)
      sum = SW'(cwp) + SW'(cansave) + SW'(2);
    else if (ttype[8:6] == 3'b011)
      sum = SW'(cwp) + SW'(NWINDOWS - 1);
    else
      sum = SW'(cwp);
    cwp_n = CWP_W'(sum % SW'(NWINDOWS));
  end
endmodule

// File: rtl/trap_level_stack.sv
`timescale 1ns/1ps
module trap_level_stack
  import trap_save_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int LV_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [LV_W-1:0] wr_lvl,
  input  frame_t          wr_frame,
  input  logic [LV_W-1:0] rd_lvl,
  output frame_t          rd_frame
);
  frame_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (we && wr_lvl != '0 && int'(wr_lvl) <= DEPTH) begin
      slots[int'(wr_lvl) - 1] <= wr_frame;
    end
  end

  always_comb begin
    rd_frame = '0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(rd_lvl) == i + 1) rd_frame = slots[i];
  end
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_save_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAXTL    = 6,
  parameter int MAXGL    = 3,
  parameter int MAXPGL   = 2,
  localparam int TL_W    = $clog2(MAXTL + 1),
  localparam int GL_W    = $clog2(MAXGL + 1),
  localparam int CWP_W   = $clog2(NWINDOWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [1:0]       trap_dest,
  input  logic [TY_W-1:0]  trap_type,
  input  logic             por_req,
  input  logic [TL_W-1:0]  cur_tl,
  input  logic [GL_W-1:0]  cur_gl,
  input  logic [7:0]       cur_ccr,
  input  logic [7:0]       cur_asi,
  input  logic [PS_W-1:0]  cur_pstat,
  input  logic [HS_W-1:0]  cur_hstat,
  input  logic [CWP_W-1:0] cur_cwp,
  input  logic [CWP_W-1:0] cur_cansave,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  cur_npc,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic [TL_W-1:0]  new_tl,
  output logic [GL_W-1:0]  new_gl,
  output logic [PS_W-1:0]  new_pstat,
  output logic [HS_W-1:0]  new_hstat,
  output logic [CWP_W-1:0] new_cwp,
  output logic             tick_lock,
  output logic             done,
  output logic [ST_W-1:0]  rd_status,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_npc,
  output logic [HS_W-1:0]  rd_hstat,
  output logic [TY_W-1:0]  rd_type
);
  logic             accept;
  logic [PS_W-1:0]  ps_nx;
  logic [HS_W-1:0]  hs_nx;
  logic [GL_W-1:0]  gl_nx;
  logic [CWP_W-1:0] cwp_nx;
  logic [7:0]       gl8, cwp8;
  frame_t           frame_in, frame_out;

  assign accept = trap_req && !por_req && (int'(cur_tl) < MAXTL);

  trap_mode_rules #(.MAXGL(MAXGL), .MAXPGL(MAXPGL)) u_rules (
    .dest(trap_dest), .pstat(cur_pstat), .hstat(cur_hstat), .gl(cur_gl),
    .pstat_n(ps_nx), .hstat_n(hs_nx), .gl_n(gl_nx)
  );

  trap_window_step #(.NWINDOWS(NWINDOWS)) u_win (
    .ttype(trap_type), .cwp(cur_cwp), .cansave(cur_cansave), .cwp_n(cwp_nx)
  );

  always_comb begin
    gl8  = 8'(cur_gl);
    cwp8 = 8'(cur_cwp);
    frame_in               = '0;
    frame_in.status[42:40] = gl8[2:0];
    frame_in.status[39:32] = cur_ccr;
    frame_in.status[31:24] = cur_asi;
    frame_in.status[20:8]  = cur_pstat;
    frame_in.status[4:0]   = cwp8[4:0];
    frame_in.pc    = cur_pstat[PS_AM] ? {32'b0, cur_pc[31:0]}  : cur_pc;
    frame_in.npc   = cur_pstat[PS_AM] ? {32'b0, cur_npc[31:0]} : cur_npc;
    frame_in.hstat = cur_hstat;
    frame_in.ttype = trap_type;
  end

  trap_level_stack #(.DEPTH(MAXTL)) u_stack (
    .clk(clk), .rst_n(rst_n), .we(accept), .wr_lvl(cur_tl + 1'b1),
    .wr_frame(frame_in), .rd_lvl(rd_lvl), .rd_frame(frame_out)
  );

  assign rd_status = frame_out.status;
  assign rd_pc     = frame_out.pc;
  assign rd_npc    = frame_out.npc;
  assign rd_hstat  = frame_out.hstat;
  assign rd_type   = frame_out.ttype;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_tl    <= '0;
      new_gl    <= '0;
      new_pstat <= '0;
      new_hstat <= '0;
      new_cwp   <= '0;
      tick_lock <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (por_req) begin
        new_tl    <= TL_W'(MAXTL);
        new_gl    <= GL_W'(MAXGL);
        new_pstat <= PS_W'(13'h014);
        new_hstat <= (cur_hstat | HS_W'(11'h024)) & ~HS_W'(11'h401);
        new_cwp   <= cur_cwp;
        tick_lock <= 1'b1;
        done      <= 1'b1;
      end else if (accept) begin
        new_tl    <= cur_tl + 1'b1;
        new_gl    <= gl_nx;
        new_pstat <= ps_nx;
        new_hstat <= hs_nx;
        new_cwp   <= cwp_nx;
        done      <= 1'b1;
      end
    end
  end

  // R4
  tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done && new_tl == $past(cur_tl) + 1'b1);

  // R11
  top_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !por_req && int'(cur_tl) >= MAXTL) |=>
      !done && $stable(new_tl) && $stable(new_pstat) && $stable(new_cwp));

  // R5
  priv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trap_dest == DEST_PRIV) |=> int'(new_gl) <= MAXPGL);

  // R8
  rcv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trap_dest[1]) |=>
      new_hstat[HS_RED] && !new_hstat[HS_IBE] && new_pstat[PS_PEF]);

  // R9
  cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trap_type[8:6] == 3'b000 && trap_type != 9'h024) |=>
      new_cwp == $past(cur_cwp));

  // R10
  por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> tick_lock && done && int'(new_tl) == MAXTL);
endmodule

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 0, por_req = 0;
  logic [1:0] trap_dest = 0;
  logic [8:0] trap_type = 0;
  logic [2:0] cur_tl = 0, cur_cwp = 0, cur_cansave = 0, rd_lvl = 0;
  logic [1:0] cur_gl = 0;
  logic [7:0] cur_ccr = 0, cur_asi = 0;
  logic [12:0] cur_pstat = 0;
  logic [10:0] cur_hstat = 0;
  logic [63:0] cur_pc = 0, cur_npc = 0;
  logic [2:0] new_tl, new_cwp;
  logic [1:0] new_gl;
  logic [12:0] new_pstat;
  logic [10:0] new_hstat, rd_hstat;
  logic tick_lock, done;
  logic [42:0] rd_status;
  logic [63:0] rd_pc, rd_npc;
  logic [8:0] rd_type;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trap_entry_unit u_dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_cwp(logic [8:0] t, logic [2:0] c, logic [2:0] s);
    if (t == 9'h024) return 3'((int'(c) + 1) % 8);
    if (t >= 9'h080 && t <= 9'h0BF) return 3'((int'(c) + int'(s) + 2) % 8);
    if (t >= 9'h0C0 && t <= 9'h0FF) return 3'((int'(c) + 7) % 8);
    return c;
  endfunction

  function automatic logic [1:0] ref_gl(logic [1:0] d, logic [1:0] g);
    int cap = (d == 2'b00) ? 2 : 3;
    return (int'(g) >= cap) ? 2'(cap) : g + 2'd1;
  endfunction

  function automatic logic [23:0] ref_stat(logic [1:0] d, logic [12:0] ps, logic [10:0] hs);
    logic [12:0] p; logic [10:0] h;
    if (d[1]) begin
      p = (ps & 13'h004) | 13'h010;
      h = (hs | 11'h024) & ~11'h401;
    end else begin
      p = (ps | 13'h010) & ~13'h00A;
      if (d[0]) begin
        p = p & ~13'h200;
        h = (hs & ~11'h420) | 11'h004;
      end else begin
        p = (p | 13'h004) & ~13'h200;
        p[9] = ps[8];
        h = hs;
      end
    end
    return {h, p};
  endfunction

  task automatic run_trap(input logic [2:0] tl, input logic [1:0] gl, input logic [12:0] ps,
                          input logic [10:0] hs, input logic [2:0] cwp, input logic [2:0] cs,
                          input logic [1:0] d, input logic [8:0] tt, input logic [63:0] pc);
    logic [42:0] st; logic [63:0] epc, enpc; logic [23:0] hp;
    logic [7:0] ccr = 8'($urandom), asi = 8'($urandom);
    @(negedge clk);
    cur_tl = tl; cur_gl = gl; cur_pstat = ps; cur_hstat = hs; cur_cwp = cwp;
    cur_cansave = cs; trap_dest = d; trap_type = tt; cur_pc = pc; cur_npc = pc + 64'd4;
    cur_ccr = ccr; cur_asi = asi; trap_req = 1;
    @(negedge clk);
    trap_req = 0; rd_lvl = tl + 3'd1;
    #1;
    st = '0; st[42:40] = {1'b0, gl}; st[39:32] = ccr; st[31:24] = asi;
    st[20:8] = ps; st[4:0] = {2'b0, cwp};
    epc = ps[3] ? {32'b0, pc[31:0]} : pc;
    enpc = ps[3] ? {32'b0, pc[31:0] + 32'd4} : pc + 64'd4;
    hp = ref_stat(d, ps, hs);
    chk("R4 done", done, 1);
    chk("R4 tl", new_tl, tl + 3'd1);
    chk("R4 saved hstat/type", {rd_hstat, rd_type}, {hs, tt});
    chk("R2 status word", rd_status, st);
    chk("R3 saved pc", {rd_pc, rd_npc}, {epc, enpc});
    chk("R5 gl", new_gl, ref_gl(d, gl));
    chk(d[1] ? "R8 status" : (d[0] ? "R7 status" : "R6 status"), {new_hstat, new_pstat}, hp);
    chk("R9 cwp", new_cwp, ref_cwp(tt, cwp, cs));
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] s_tl, s_cwp; logic [1:0] s_gl; logic [12:0] s_ps; logic [10:0] s_hs;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_lvl = 3'd1;
    #1;
    // R1 reset state
    chk("R1 outputs", {new_tl, new_gl, new_pstat, new_hstat, new_cwp, tick_lock, done}, 0);
    chk("R1 stack", {rd_status, rd_pc, rd_hstat, rd_type}, 0);

    // R9 wrap corners
    run_trap(3'd0, 2'd0, 13'h000, 11'h000, 3'd7, 3'd0, 2'b00, 9'h024, 64'h1000);
    run_trap(3'd1, 2'd1, 13'h100, 11'h001, 3'd0, 3'd3, 2'b01, 9'h0C4, 64'h2000);
    run_trap(3'd2, 2'd1, 13'h0FF, 11'h7FF, 3'd6, 3'd7, 2'b00, 9'h0BF, 64'h3000);
    // R5 saturation
    run_trap(3'd0, 2'd2, 13'h000, 11'h000, 3'd1, 3'd0, 2'b00, 9'h010, 64'h40);
    run_trap(3'd0, 2'd2, 13'h000, 11'h000, 3'd1, 3'd0, 2'b01, 9'h010, 64'h40);
    run_trap(3'd4, 2'd3, 13'h1FFF, 11'h7FF, 3'd1, 3'd0, 2'b10, 9'h005, 64'h40);
    // R3 truncation
    run_trap(3'd5, 2'd0, 13'h008, 11'h000, 3'd2, 3'd0, 2'b11, 9'h034, 64'hDEAD_BEEF_1234_5678);
    run_trap(3'd5, 2'd0, 13'h000, 11'h000, 3'd2, 3'd0, 2'b00, 9'h034, 64'hDEAD_BEEF_1234_5678);

    // random mix
    for (int k = 0; k < 80; k++) begin
      logic [8:0] tt;
      case ($urandom % 5)
        0: tt = 9'h024;
        1: tt = 9'h080 + 9'($urandom % 64);
        2: tt = 9'h0C0 + 9'($urandom % 64);
        3: tt = 9'($urandom % 36);
        default: tt = 9'h100 + 9'($urandom % 256);
      endcase
      run_trap(3'($urandom % 6), 2'($urandom), 13'($urandom), 11'($urandom),
               3'($urandom), 3'($urandom), 2'($urandom), tt,
               {32'($urandom), 32'($urandom)});
    end

    // R11 dropped request at top level
    s_tl = new_tl; s_gl = new_gl; s_ps = new_pstat; s_hs = new_hstat; s_cwp = new_cwp;
    @(negedge clk);
    cur_tl = 3'd6; trap_dest = 2'b01; trap_type = 9'h024; cur_cwp = s_cwp + 3'd3; trap_req = 1;
    @(negedge clk);
    trap_req = 0;
    chk("R11 done low", done, 0);
    chk("R11 outputs held", {new_tl, new_gl, new_pstat, new_hstat, new_cwp},
        {s_tl, s_gl, s_ps, s_hs, s_cwp});

    // R10 / R12 power-on with simultaneous trap
    @(negedge clk);
    cur_tl = 3'd1; cur_hstat = 11'h7FF; cur_cwp = 3'd5; trap_type = 9'h024;
    trap_req = 1; por_req = 1;
    @(negedge clk);
    trap_req = 0; por_req = 0;
    chk("R10 por values", {new_tl, new_gl, new_pstat, new_hstat, new_cwp, tick_lock, done},
        {3'd6, 2'd3, 13'h014, 11'h3FE, 3'd5, 1'b1, 1'b1});
    chk("R12 por wins over trap", new_tl, 3'd6);
    run_trap(3'd0, 2'd0, 13'h000, 11'h000, 3'd0, 3'd0, 2'b00, 9'h001, 64'h80);
    chk("R10 tick_lock held", tick_lock, 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule